// File: doc/BRIEF.md
# USB Device Address Filter

This block keeps the function address that a USB device receives during enumeration and decides, for every incoming token, whether the token is meant for this device. Each token's 7-bit address is compared against the effective device address. A registered match flag then tells the downstream packet logic whether to accept the packet or drop it.

Software loads the address through a small register port that has an address field and a separate enable bit. Assigning an address takes two steps. First the new address is written with the enable bit at zero, so the device keeps answering at address 0 while it sends the status-stage zero-length IN packet. Then a second write sets the enable bit, and only that write makes the address live. If either the stored field or the enable bit is zero, the device answers at the default address 0.

Three events return the block to its post-reset state: an asynchronous hardware reset, the controller-disable input, and a detected bus reset.

Top module: `usb_addr_filter`

## Requirements
- R1: After hardware reset (rstN low), the read-back address is 0, the read-back enable is 0, and a token to address 0 matches.
- R2: `matchValid` is high exactly one cycle after `tokValid`. In that cycle `match` is 1 only if the token address equals the effective address as it stood when the token was presented.
- R3: While the enable bit is 0, the effective address is 0. A token to the stored nonzero address does not match, and a token to address 0 does.
- R4: A write with `wrAddrEn` = 0 stores `wrAddr` and leaves the enable bit at 0.
- R5: A write with `wrAddrEn` = 1 whose `wrAddr` equals the stored nonzero address sets the enable bit. From then on, tokens match that address and no longer match address 0.
- R6: A write with `wrAddrEn` = 1 and a `wrAddr` different from the stored address stores the new address and clears the enable bit, so the new address does not become live.
- R7: A write with `wrAddrEn` = 1 while both the stored and written address are 0 is ignored, and the enable bit stays 0. The enable bit is never 1 while the stored address is 0.
- R8: A later write with `wrAddrEn` = 0 clears the enable bit, which restores the effective address 0.
- R9: While `ctrlOn` is low, the address and enable bit are held at 0 and register writes have no effect.
- R10: A cycle with `busResetSeen` high clears the address and enable bit at the next clock edge. The clear takes priority over a write in the same cycle.
- R11: `rdAddr` and `rdAddrEn` always show the stored address field and enable bit exactly as held.
- R12: `match` is 0 in every cycle that does not follow a `tokValid` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous hardware reset, active low |
| ctrlOn | input | 1 | Controller enable; low clears and holds the address state |
| busResetSeen | input | 1 | One-cycle pulse when a bus reset is detected |
| wrStb | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Address field of the write |
| wrAddrEn | input | 1 | Enable bit of the write |
| rdAddr | output | ADDR_W | Stored address field |
| rdAddrEn | output | 1 | Stored enable bit |
| tokValid | input | 1 | Token received strobe |
| tokAddr | input | ADDR_W | Address field of the received token |
| matchValid | output | 1 | Match result valid, one cycle after `tokValid` |
| match | output | 1 | Token addressed to this device |

## Verification
The bench builds the block with its default `ADDR_W` of 7, so the full 128-entry address space is in play.

Random writes are biased toward repeating the stored address. This regularly reaches both the same-address enable path and the changed-address path, including address 0 and 127.

Random tokens are biased toward the effective address and toward 0. This makes both the live-address and default-address decisions frequent.

Bus-reset and disable events are interleaved with these writes and tokens. Directed cases add a write in the same cycle as a bus reset, and writes attempted while the controller is off.

// File: rtl/usbaf_pkg.sv
package usbaf_pkg;
  // Strobes from control to datapath for one clock cycle.
  typedef struct packed {
    logic clear;    // force address and enable to zero
    logic store;    // load the written address
    logic enVal;    // enable value loaded together with store
  } ctrlStrb_t;
endpackage

// File: rtl/usbaf_ctrl.sv
module usbaf_ctrl
  import usbaf_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlOn,
  input  logic              busResetSeen,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrAddrEn,
  input  logic [ADDR_W-1:0] curAddr,
  output ctrlStrb_t         strb
);
  localparam logic [ADDR_W-1:0] ZERO_ADDR = '0;

  logic clearNow;
  logic sameAddr;
  logic nonZero;

  assign clearNow = !ctrlOn || busResetSeen;
  assign sameAddr = (wrAddr == curAddr);
  assign nonZero  = (wrAddr != ZERO_ADDR);

  always_comb begin
    strb.clear = clearNow;
    strb.store = wrStb && !clearNow;
    // Enable goes live only when it confirms the address already held.
    strb.enVal = wrAddrEn && sameAddr && nonZero;
  end

  // A clear request never coexists with a store.
  AST_CLEAR_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |-> !strb.store); // R10

  // Disabled controller suppresses every write.
  AST_OFF_NO_STORE: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlOn |-> !strb.store); // R9
endmodule

// File: rtl/usbaf_dp.sv
module usbaf_dp
  import usbaf_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              tokValid,
  input  logic [ADDR_W-1:0] tokAddr,
  output logic [ADDR_W-1:0] addrQ,
  output logic              enQ,
  output logic              matchValid,
  output logic              match
);
  localparam logic [ADDR_W-1:0] DEF_ADDR = '0;

  logic [ADDR_W-1:0] effAddr;

  // Effective address falls back to the default when either field is zero.
  assign effAddr = (enQ && (addrQ != DEF_ADDR)) ? addrQ : DEF_ADDR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      enQ   <= 1'b0;
    end else if (strb.clear) begin
      addrQ <= '0;
      enQ   <= 1'b0;
    end else if (strb.store) begin
      addrQ <= wrAddr;
      enQ   <= strb.enVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchValid <= 1'b0;
      match      <= 1'b0;
    end else begin
      matchValid <= tokValid;
      match      <= tokValid && (tokAddr == effAddr);
    end
  end

  AST_EN_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    enQ |-> (addrQ != DEF_ADDR)); // R7

  AST_EN_RISE_SAME: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enQ) |-> (addrQ == $past(addrQ))); // R5

  AST_CLEAR_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (addrQ == DEF_ADDR) && !enQ); // R10

  AST_MATCH_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    tokValid |=> matchValid); // R2

  AST_MATCH_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !tokValid |=> !match && !matchValid); // R12

  AST_DEFAULT_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (!enQ && tokValid && (tokAddr != DEF_ADDR)) |=> !match); // R3
endmodule

// File: rtl/usb_addr_filter.sv
module usb_addr_filter
  import usbaf_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlOn,
  input  logic              busResetSeen,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrAddrEn,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rdAddrEn,
  input  logic              tokValid,
  input  logic [ADDR_W-1:0] tokAddr,
  output logic              matchValid,
  output logic              match
);
  ctrlStrb_t         strb;
  logic [ADDR_W-1:0] addrQ;
  logic              enQ;

  usbaf_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .ctrlOn       (ctrlOn),
    .busResetSeen (busResetSeen),
    .wrStb        (wrStb),
    .wrAddr       (wrAddr),
    .wrAddrEn     (wrAddrEn),
    .curAddr      (addrQ),
    .strb         (strb)
  );

  usbaf_dp #(.ADDR_W(ADDR_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrAddr     (wrAddr),
    .tokValid   (tokValid),
    .tokAddr    (tokAddr),
    .addrQ      (addrQ),
    .enQ        (enQ),
    .matchValid (matchValid),
    .match      (match)
  );

  // Read-back reflects held state directly (R11).
  assign rdAddr   = addrQ;
  assign rdAddrEn = enQ;
endmodule

// File: tb/tb_usb_addr_filter.sv
`timescale 1ns/1ps
module tb_usb_addr_filter;
  localparam int ADDR_W = 7;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              ctrlOn = 1'b1;
  logic              busResetSeen = 1'b0;
  logic              wrStb = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic              wrAddrEn = 1'b0;
  logic [ADDR_W-1:0] rdAddr;
  logic              rdAddrEn;
  logic              tokValid = 1'b0;
  logic [ADDR_W-1:0] tokAddr = '0;
  logic              matchValid;
  logic              match;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  logic [ADDR_W-1:0] mAddr;
  logic              mEn;

  always #10 clk = ~clk;

  usb_addr_filter #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .ctrlOn(ctrlOn), .busResetSeen(busResetSeen),
    .wrStb(wrStb), .wrAddr(wrAddr), .wrAddrEn(wrAddrEn),
    .rdAddr(rdAddr), .rdAddrEn(rdAddrEn),
    .tokValid(tokValid), .tokAddr(tokAddr),
    .matchValid(matchValid), .match(match)
  );

  function automatic logic [ADDR_W-1:0] effOf(logic [ADDR_W-1:0] a, logic e);
    return (e && a != '0) ? a : '0;
  endfunction

  function automatic logic nextEn(logic [ADDR_W-1:0] oldA, logic [ADDR_W-1:0] a, logic e);
    return e && (a == oldA) && (a != '0);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkRegs(string req);
    check({req, " addr"}, 32'(rdAddr), 32'(mAddr));
    check({req, " en"}, 32'(rdAddrEn), 32'(mEn));
  endtask

  task automatic doWrite(logic [ADDR_W-1:0] a, logic e);
    @(negedge clk);
    wrStb = 1'b1; wrAddr = a; wrAddrEn = e;
    @(negedge clk);
    wrStb = 1'b0;
    if (ctrlOn) begin
      mEn   = nextEn(mAddr, a, e);
      mAddr = a;
    end
  endtask

  task automatic sendToken(logic [ADDR_W-1:0] a, string req);
    logic expM;
    expM = (a == effOf(mAddr, mEn));
    @(negedge clk);
    tokValid = 1'b1; tokAddr = a;
    @(negedge clk);
    tokValid = 1'b0;
    check({req, " matchValid"}, 32'(matchValid), 32'd1);
    check({req, " match"}, 32'(match), 32'(expM));
  endtask

  task automatic busReset();
    @(negedge clk);
    busResetSeen = 1'b1;
    @(negedge clk);
    busResetSeen = 1'b0;
    mAddr = '0; mEn = 1'b0;
  endtask

  task automatic offPulse();
    @(negedge clk);
    ctrlOn = 1'b0;
    @(negedge clk);
    ctrlOn = 1'b1;
    mAddr = '0; mEn = 1'b0;
  endtask

  initial begin
    #(20 * 60000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    mAddr = '0; mEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkRegs("R1");
    sendToken(7'd0, "R1 default");
    // R12 idle: no token, no match
    @(negedge clk);
    check("R12 idle match", 32'(match), 32'd0);
    check("R12 idle valid", 32'(matchValid), 32'd0);

    // R4 store with enable low
    doWrite(7'd42, 1'b0);
    checkRegs("R4");
    check("R4 en stays 0", 32'(rdAddrEn), 32'd0);
    // R3 default address while disabled
    sendToken(7'd42, "R3 stored");
    sendToken(7'd0, "R3 default");
    check("R3 no match stored", 32'(mEn), 32'd0);

    // R5 enable confirms same address
    doWrite(7'd42, 1'b1);
    checkRegs("R5");
    check("R5 en set", 32'(rdAddrEn), 32'd1);
    sendToken(7'd42, "R5 live");
    sendToken(7'd0, "R5 not default");
    sendToken(7'd43, "R2 other");

    // R11 read-back exact
    check("R11 rdAddr", 32'(rdAddr), 32'd42);

    // R6 enable with different address stays off
    doWrite(7'd99, 1'b1);
    checkRegs("R6");
    check("R6 en zero", 32'(rdAddrEn), 32'd0);
    sendToken(7'd99, "R6 not live");

    // R8 clearing enable
    doWrite(7'd99, 1'b1);
    check("R8 en set first", 32'(rdAddrEn), 32'd1);
    doWrite(7'd99, 1'b0);
    checkRegs("R8");
    sendToken(7'd0, "R8 back to default");

    // R7 enable with zero address ignored
    busReset();
    doWrite(7'd0, 1'b1);
    checkRegs("R7");
    check("R7 en stays 0", 32'(rdAddrEn), 32'd0);

    // R10 bus reset clears, beats simultaneous write
    doWrite(7'd5, 1'b0);
    doWrite(7'd5, 1'b1);
    @(negedge clk);
    busResetSeen = 1'b1; wrStb = 1'b1; wrAddr = 7'd9; wrAddrEn = 1'b0;
    @(negedge clk);
    busResetSeen = 1'b0; wrStb = 1'b0;
    mAddr = '0; mEn = 1'b0;
    checkRegs("R10");
    sendToken(7'd0, "R10 default");

    // R9 disable clears and blocks writes
    doWrite(7'd17, 1'b0);
    doWrite(7'd17, 1'b1);
    @(negedge clk);
    ctrlOn = 1'b0;
    @(negedge clk);
    mAddr = '0; mEn = 1'b0;
    checkRegs("R9 cleared");
    doWrite(7'd33, 1'b0);
    checkRegs("R9 write ignored");
    @(negedge clk);
    ctrlOn = 1'b1;
    @(negedge clk);
    checkRegs("R9 after");

    // R1 hardware reset mid-operation
    doWrite(7'd127, 1'b0);
    doWrite(7'd127, 1'b1);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    mAddr = '0; mEn = 1'b0;
    checkRegs("R1 rerst");

    // Random phase
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom % 16;
      if (op < 6) begin
        logic [ADDR_W-1:0] a;
        a = ($urandom % 2) ? mAddr : ADDR_W'($urandom);
        if ($urandom % 8 == 0) a = '0;
        doWrite(a, 1'($urandom));
        checkRegs("R11 rand");
      end else if (op < 14) begin
        logic [ADDR_W-1:0] a;
        case ($urandom % 3)
          0: a = effOf(mAddr, mEn);
          1: a = '0;
          default: a = ADDR_W'($urandom);
        endcase
        sendToken(a, "R2 rand");
      end else if (op == 14) begin
        busReset();
        checkRegs("R10 rand");
      end else begin
        offPulse();
        checkRegs("R9 rand");
      end
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule